// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial side of an SPI master. When the host writes a byte into the transmit buffer while the engine is idle, a full-duplex exchange of eight bits starts at once. No separate start command is needed. Outgoing bits leave most significant bit first on the serial output. Incoming bits from the serial input are collected in the same sequence. When the last bit has been handled, the received byte is placed in a read buffer and a completion flag is raised.

Three control inputs shape the waveform:

- The idle level of the serial clock.
- Whether the first data bit is presented before the first clock edge.
- Whether input data is sampled at mid-bit or at the end of the bit.

The half-bit duration comes from one of two sources. The first is a fixed division of the system clock. The second is one reference period of a programmable period count, which gives a bit clock at half the reference rate. The serial output driver can be switched off. In that case the engine still clocks in data on every buffer write, so it can act as a receive-only line monitor.

Top module: `spi_master_engine`

## Requirements
- R1: A buffer write while idle (and not blocked by R4) makes `busy` high in the next cycle. It loads the byte for transmission.
- R2: Bit i of a transfer (i = 0..7) carries `wr_data[7-i]` on `sdo` for the whole bit time, most significant bit first.
- R3: The half-bit length L in system clocks is set by `rate_sel`: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 32, and 4 to 7 give `tmr_period`+1. With the write captured on edge E0, `busy` stays high through edge E0+16L-1 and is low after edge E0+16L.
- R4: When `rate_sel` is 4 to 7 and `tmr_period` is 0, a buffer write is ignored. No transfer starts, and `sck` and `sdo` keep their values.
- R5: While no transfer runs, `sck` equals `cpol`.
- R6: With `early_out`=1, `sck` stays at its idle level for the first half-bit while `sdo` already shows the first bit. With `early_out`=0, `sck` leaves its idle level on the same edge that starts the transfer. In both cases `sck` toggles at every half-bit boundary.
- R7: With `smp_end`=0, each input bit is taken at the end of the first half of its bit time. With `smp_end`=1, it is taken at the end of the bit time.
- R8: On the edge that ends a transfer, `rd_data` gets the received byte (first received bit in bit 7) and `done_irq` is set. `done_irq` stays set until `irq_clr` is pulsed.
- R9: With `sdo_en`=0, `sdo_oe` is low and transfers and reception proceed unchanged.
- R10: `rx_full` is set when a received byte is loaded. It is cleared by `rd_ack`.
- R11: A buffer write during a transfer sets `wcol` and has no effect on the data being shifted. `wcol` is cleared by `wcol_clr`.
- R12: Between transfers `sdo` holds the last bit driven (bit 0 of the previous byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_ack | input | 1 | Host has read the receive buffer |
| irq_clr | input | 1 | Clear the completion flag |
| wcol_clr | input | 1 | Clear the write-collision flag |
| cpol | input | 1 | Idle level of `sck` |
| early_out | input | 1 | First bit valid before first clock edge |
| smp_end | input | 1 | Sample input at end of bit (1) or mid-bit (0) |
| rate_sel | input | 3 | Bit-rate source select |
| tmr_period | input | 8 | Reference period for timer-based rate |
| sdo_en | input | 1 | Serial output driver enable |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rd_data | output | 8 | Receive buffer |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Transfer complete flag |
| rx_full | output | 1 | Receive buffer holds unread data |
| wcol | output | 1 | Write collision flag |

## Verification
Results fall due at the following times, counted from the edge E0 that captures the write:

- `busy` rises one edge after E0.
- The serial clock first moves at E0 (when `early_out`=0) or at E0+L.
- Each input sample is taken at E0+(2i+1)L or E0+(2i+2)L.
- `busy` drops, and the received byte and `done_irq` appear, exactly at E0+16L.
- Collision and clear flags follow one edge after their strobe.

The bench counts the edges m since E0 and checks at the falling edge after each one. It asserts `busy` at m=16L-1 and completion at m=16L. The serial input is changed at half-bit granularity, so the byte received proves which of the two sample points was used.

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ack,
  input  logic          irq_clr,
  input  logic          wcol_clr,
  input  logic          cpol,
  input  logic          early_out,
  input  logic          smp_end,
  input  logic [2:0]    rate_sel,
  input  logic [PW-1:0] tmr_period,
  input  logic          sdo_en,
  input  logic          sdi,
  output logic          sck,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done_irq,
  output logic          rx_full,
  output logic          wcol
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam int CW = PW + 1;

  logic [CW-1:0] half_len, cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] tx_sh, rx_sh, rx_buf;
  logic          phase, sdo_q;

  always_comb begin
    case (rate_sel)
      3'd0:    half_len = CW'(2);
      3'd1:    half_len = CW'(4);
      3'd2:    half_len = CW'(8);
      3'd3:    half_len = CW'(32);
      default: half_len = {1'b0, tmr_period} + CW'(1);
    endcase
  end

  wire bad_period = rate_sel[2] && (tmr_period == '0);
  wire start      = wr_en && !busy && !bad_period;
  wire tick       = busy && (cnt == half_len - CW'(1));
  wire last_bit   = (bit_idx == BW'(DW - 1));
  wire [DW-1:0] rx_next = {rx_sh[DW-2:0], sdi};

  assign sck     = cpol ^ (busy & (early_out ? phase : ~phase));
  assign sdo     = sdo_q;
  assign sdo_oe  = sdo_en;
  assign rd_data = rx_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      phase    <= 1'b0;
      bit_idx  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_buf   <= '0;
      sdo_q    <= 1'b0;
      done_irq <= 1'b0;
      rx_full  <= 1'b0;
      wcol     <= 1'b0;
    end else begin
      if (rd_ack)   rx_full  <= 1'b0;
      if (irq_clr)  done_irq <= 1'b0;
      if (wcol_clr) wcol     <= 1'b0;
      if (wr_en && busy) wcol <= 1'b1;

      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        phase   <= 1'b0;
        bit_idx <= '0;
        tx_sh   <= wr_data;
        sdo_q   <= wr_data[DW-1];
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + CW'(1);
        if (tick) begin
          if (!phase) begin
            phase <= 1'b1;
            if (!smp_end) rx_sh <= rx_next;
          end else begin
            phase <= 1'b0;
            if (smp_end) rx_sh <= rx_next;
            if (last_bit) begin
              busy     <= 1'b0;
              rx_buf   <= smp_end ? rx_next : rx_sh;
              done_irq <= 1'b1;
              rx_full  <= 1'b1;
            end else begin
              bit_idx <= bit_idx + BW'(1);
              tx_sh   <= tx_sh << 1;
              sdo_q   <= tx_sh[DW-2];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          cpol,
  input logic [2:0]    rate_sel,
  input logic [PW-1:0] tmr_period,
  input logic          sck,
  input logic          sdo,
  input logic          busy,
  input logic          done_irq,
  input logic          rx_full,
  input logic          wcol
);
  wire blocked = rate_sel[2] && (tmr_period == '0);

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !blocked) |=> busy);

  assert_bad_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && blocked) |=> !busy);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_irq && rx_full));

  assert_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);

  assert_sdo_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !(wr_en && !blocked)) |=> $stable(sdo));
endmodule

bind spi_master_engine spi_master_engine_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cpol(cpol), .rate_sel(rate_sel),
  .tmr_period(tmr_period), .sck(sck), .sdo(sdo), .busy(busy),
  .done_irq(done_irq), .rx_full(rx_full), .wcol(wcol)
);

// File: tb/spi_master_engine_tb.sv
module spi_master_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_ack = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0;
  logic [7:0] wr_data = '0, tmr_period = '0;
  logic cpol = 1'b0, early_out = 1'b0, smp_end = 1'b0, sdo_en = 1'b1, sdi = 1'b0;
  logic [2:0] rate_sel = '0;
  logic sck, sdo, sdo_oe, busy, done_irq, rx_full, wcol;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_master_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_ack(rd_ack),
    .irq_clr(irq_clr), .wcol_clr(wcol_clr), .cpol(cpol), .early_out(early_out),
    .smp_end(smp_end), .rate_sel(rate_sel), .tmr_period(tmr_period), .sdo_en(sdo_en),
    .sdi(sdi), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .rd_data(rd_data),
    .busy(busy), .done_irq(done_irq), .rx_full(rx_full), .wcol(wcol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [2:0] rs, input logic [7:0] pr);
    case (rs)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 32;
      default: return int'(pr) + 1;
    endcase
  endfunction

  task automatic clear_flags();
    @(negedge clk);
    rd_ack = 1'b1; irq_clr = 1'b1; wcol_clr = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0; irq_clr = 1'b0; wcol_clr = 1'b0;
    check(!done_irq && !rx_full && !wcol, "R10 R8 R11 clear", {done_irq, rx_full, wcol}, 0);
  endtask

  // pa drives the first half of each bit, pb the second half
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] pa, input logic [7:0] pb,
                          input logic [2:0] rs, input logic [7:0] pr, input logic cp,
                          input logic eo, input logic sm, input logic oe, input int coll_m);
    int L, e_sck, e_sdo;
    logic [7:0] exp_rx;
    clear_flags();
    L = half_of(rs, pr);
    e_sck = 0; e_sdo = 0;
    exp_rx = sm ? pb : pa;
    @(negedge clk);
    rate_sel = rs; tmr_period = pr; cpol = cp; early_out = eo; smp_end = sm; sdo_en = oe;
    wr_data = tx; wr_en = 1'b1;
    @(posedge clk);
    for (int m = 0; m <= 16 * L; m++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (m == 0) begin
        check(busy == 1'b1, "R1 busy after write", busy, 1);
        check(sck == (eo ? cp : ~cp), "R6 first-half clock level", sck, eo ? cp : ~cp);
        check(sdo == tx[7], "R6 first bit on sdo", sdo, tx[7]);
      end
      if (m < 16 * L) begin
        int h, i;
        logic hb, exp_sck;
        h = m / L; i = h / 2; hb = h % 2;
        exp_sck = cp ^ (eo ? hb : ~hb);
        if (sck !== exp_sck) e_sck++;
        if (sdo !== tx[7 - i]) e_sdo++;
        sdi = hb ? pb[7 - i] : pa[7 - i];
      end
      if (coll_m >= 0 && m == coll_m) begin
        wr_data = ~tx; wr_en = 1'b1;
      end
      if (coll_m >= 0 && m == coll_m + 1)
        check(wcol == 1'b1, "R11 collision flag", wcol, 1);
      if (m == 16 * L - 1) check(busy == 1'b1, "R3 busy at last cycle", busy, 1);
    end
    check(e_sck == 0, "R6 R3 sck waveform errors", e_sck, 0);
    check(e_sdo == 0, "R2 R11 sdo bit errors", e_sdo, 0);
    check(busy == 1'b0, "R3 busy drops at 16L", busy, 0);
    check(rd_data == exp_rx, "R7 R8 received byte", rd_data, exp_rx);
    check(done_irq && rx_full, "R8 R10 completion flags", {done_irq, rx_full}, 3);
    check(sck == cp, "R5 idle level", sck, cp);
    check(sdo_oe == oe, "R9 output enable", sdo_oe, oe);
    repeat (3) @(negedge clk);
    check(sdo == tx[0], "R12 sdo holds last bit", sdo, tx[0]);
    check(done_irq == 1'b1, "R8 flag held", done_irq, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done_irq && !rx_full && !wcol, "R8 R10 R11 reset flags",
          {busy, done_irq, rx_full, wcol}, 0);
    check(sck == 1'b0 && rd_data == 8'h00, "R5 reset idle", {sck, rd_data}, 0);
  endtask

  task automatic t_bad_period();
    logic prev_sdo;
    @(negedge clk);
    rate_sel = 3'd4; tmr_period = 8'h00; cpol = 1'b1;
    prev_sdo = sdo;
    wr_data = ~{7'h00, prev_sdo}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R4 zero period blocks start", busy, 0);
    check(sck == 1'b1 && sdo == prev_sdo, "R4 pins unchanged", {sck, sdo}, {1'b1, prev_sdo});
  endtask

  initial begin
    t_reset();
    run_xfer(8'hA5, 8'h3C, 8'hC3, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    run_xfer(8'h5A, 8'h3C, 8'hC3, 3'd1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, -1);
    run_xfer(8'h81, 8'h96, 8'h69, 3'd2, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, -1);
    run_xfer(8'h7E, 8'hF0, 8'h0F, 3'd3, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, -1);
    run_xfer(8'hC6, 8'h55, 8'hAA, 3'd4, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1, -1);
    run_xfer(8'h00, 8'hE1, 8'h1E, 3'd6, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    run_xfer(8'hB4, 8'h12, 8'h34, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 9);
    t_bad_period();
    clear_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule